// File: doc/BRIEF.md
# Locked Indexed Configuration Register File

This block is a byte-wide configuration store that software reaches through two I/O ports. A write to the index port selects one of 256 register slots. A later write or read on the data port then acts on the selected slot. Every slot has its own reset value, its own write mask and its own forced-one bits. Slots with no defined function hold a constant and ignore writes.

All data-port writes are refused unless the lock register holds a fixed unlock key. The lock register itself is the one exception and can always be written. On reads, some indices are treated specially. One index returns a byte supplied from outside the block. When a compatibility input is high, a group of indices reads as all ones. The whole register image leaves the block as a flat vector, and one bit of it is also brought out on its own as an auxiliary port enable. Neighbouring logic uses these outputs to steer memory mapping, caches and interrupts.

Top module: `idxcfg_regfile`

## Requirements
- R1: A write to I/O address 22h latches the written byte as the current index. Later data-port accesses use that index, starting with the access in the next cycle.
- R2: A write to data port 23h stores into the indexed register only while register 03h holds C5h. A write to index 03h is accepted at any time, so writing a value other than C5h locks the file again.
- R3: Stored values are masked with AND as follows: 14h BFh, 15h F1h, 1Ch 1Fh, 1Eh 40h, 22h FDh, 28h 3Fh, 36h E5h, 37h EFh, 3Dh 07h, 40h 3Fh. All other writable registers store the full byte.
- R4: Register 21h stores (data AND BBh) OR 04h, and register 2Bh stores (data AND BFh) OR 40h. After any accepted write, bit 2 of 21h and bit 6 of 2Bh read as 1.
- R5: A write to register 35h replaces only bits [7:4]. Bits [3:0] keep their held value, which is 0 after reset.
- R6: After reset, the following registers hold non-zero values: 02h=0Fh, 10h=F1h, 11h=FFh, 15h=20h, 16h=30h, 19h=04h, 3Ch=03h, 3Dh=01h, 40h=03h. Every other register holds 00h.
- R7: While compat_mode is high, a data-port read of index 20h or of any index from C0h upward returns FFh.
- R8: A data-port read of index 3Fh returns rtc_shadow. Writes to 3Fh have no effect on what is read there.
- R9: aux_port92_en equals bit 4 of register 29h.
- R10: A read of the index port or of any address other than 23h returns FFh. Indices with no defined register read 00h and ignore writes, and register 02h is read-only at 0Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read data for io_addr, combinational |
| compat_mode | input | 1 | Makes index 20h and indices C0h and above read as FFh |
| rtc_shadow | input | 8 | External byte returned for index 3Fh |
| cfg_flat | output | 2048 | All 256 registers; register n sits at bits [8n+7:8n] |
| aux_port92_en | output | 1 | Auxiliary port enable, bit 4 of register 29h |

## Verification
Index and register writes are captured at the clock edge on which io_wr is high. The new index or register value is therefore visible one edge after the strobe, on cfg_flat, aux_port92_en and on the data-port read path. io_rdata is a combinational decode of io_addr, the current index and the register state, so a read's result is due in the same cycle. The bench drives strobes on falling edges and drops them one cycle later. It samples io_rdata a short delay after a falling edge, which places every read at least half a cycle after the last write's capture edge. The checker assertions use |=> for write effects and same-cycle implication for read decoding.

// File: rtl/idxcfg_pkg.sv
package idxcfg_pkg;

   localparam int BYTE_W = 8;

   // slots that hold a flip-flop register
   function automatic logic is_stored(input logic [7:0] idx);
      case (idx)
         8'h03, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16,
         8'h17, 8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h1E, 8'h20, 8'h21,
         8'h22, 8'h25, 8'h26, 8'h27, 8'h28, 8'h29, 8'h2A, 8'h2B,
         8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37,
         8'h38, 8'h39, 8'h3A, 8'h3B, 8'h3C, 8'h3D, 8'h40, 8'h41,
         8'h44:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] rst_val(input logic [7:0] idx);
      case (idx)
         8'h02:   return 8'h0F;
         8'h10:   return 8'hF1;
         8'h11:   return 8'hFF;
         8'h15:   return 8'h20;
         8'h16:   return 8'h30;
         8'h19:   return 8'h04;
         8'h3C:   return 8'h03;
         8'h3D:   return 8'h01;
         8'h40:   return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

   // bits taken from the written byte
   function automatic logic [7:0] and_mask(input logic [7:0] idx);
      if (!is_stored(idx)) return 8'h00;
      case (idx)
         8'h14:   return 8'hBF;
         8'h15:   return 8'hF1;
         8'h1C:   return 8'h1F;
         8'h1E:   return 8'h40;
         8'h21:   return 8'hBB;
         8'h22:   return 8'hFD;
         8'h28:   return 8'h3F;
         8'h2B:   return 8'hBF;
         8'h35:   return 8'hF0;
         8'h36:   return 8'hE5;
         8'h37:   return 8'hEF;
         8'h3D:   return 8'h07;
         8'h40:   return 8'h3F;
         default: return 8'hFF;
      endcase
   endfunction

   // bits set on every accepted write
   function automatic logic [7:0] or_mask(input logic [7:0] idx);
      case (idx)
         8'h21:   return 8'h04;
         8'h2B:   return 8'h40;
         default: return 8'h00;
      endcase
   endfunction

   // bits kept from the old value on a write
   function automatic logic [7:0] keep_mask(input logic [7:0] idx);
      case (idx)
         8'h35:   return 8'h0F;
         default: return 8'h00;
      endcase
   endfunction

   typedef enum logic [1:0] {
      SEL_INDEX = 2'd0,
      SEL_DATA  = 2'd1,
      SEL_NONE  = 2'd2
   } port_sel_e;

endpackage

// File: rtl/idxcfg_index_latch.sv
module idxcfg_index_latch #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] din,
   output logic [IDX_W-1:0] idx_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (load)
         idx_q <= din;
   end
endmodule

// File: rtl/idxcfg_cell.sv
module idxcfg_cell
   import idxcfg_pkg::*;
#(
   parameter logic [7:0] IDX = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] q
);
   localparam logic       STORED = is_stored(IDX);
   localparam logic [7:0] RSTV   = rst_val(IDX);
   localparam logic [7:0] ANDM   = and_mask(IDX);
   localparam logic [7:0] ORM    = or_mask(IDX);
   localparam logic [7:0] KEEPM  = keep_mask(IDX);

   generate
      if (STORED) begin : g_flop
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= RSTV;
            else if (wr_en)
               q <= (q & KEEPM) | (wdata & ANDM) | ORM;
         end
      end else begin : g_const
         logic unused_sink;
         assign unused_sink = &{1'b0, clk, rst_n, wr_en, wdata};
         assign q = RSTV;
      end
   endgenerate
endmodule

// File: rtl/idxcfg_read_mux.sv
module idxcfg_read_mux
   import idxcfg_pkg::*;
#(
   parameter int              ADDR_W       = 16,
   parameter int              IDX_W        = 8,
   parameter logic [15:0]     IDX_PORT     = 16'h0022,
   parameter logic [15:0]     DAT_PORT     = 16'h0023,
   parameter logic [7:0]      SHADOW_IDX   = 8'h3F,
   parameter logic [7:0]      COMPAT_IDX   = 8'h20,
   parameter logic [7:0]      COMPAT_FLOOR = 8'hC0,
   localparam int             NUM_REGS     = 1 << IDX_W
) (
   input  logic [ADDR_W-1:0]          io_addr,
   input  logic [IDX_W-1:0]           cur_index,
   input  logic [NUM_REGS*BYTE_W-1:0] cfg_flat,
   input  logic                       compat_mode,
   input  logic [BYTE_W-1:0]          rtc_shadow,
   output logic [BYTE_W-1:0]          rdata
);
   port_sel_e         sel;
   logic [BYTE_W-1:0] slot;
   logic              compat_hit;

   always_comb begin
      if (io_addr == ADDR_W'(DAT_PORT))
         sel = SEL_DATA;
      else if (io_addr == ADDR_W'(IDX_PORT))
         sel = SEL_INDEX;
      else
         sel = SEL_NONE;
   end

   assign slot       = cfg_flat[{cur_index, 3'b000} +: BYTE_W];
   assign compat_hit = compat_mode &&
                       ((cur_index == IDX_W'(COMPAT_IDX)) ||
                        (cur_index >= IDX_W'(COMPAT_FLOOR)));

   always_comb begin
      rdata = '1;
      if (sel == SEL_DATA) begin
         if (compat_hit)
            rdata = '1;
         else if (cur_index == IDX_W'(SHADOW_IDX))
            rdata = rtc_shadow;
         else
            rdata = slot;
      end
   end
endmodule

// File: rtl/idxcfg_regfile.sv
module idxcfg_regfile
   import idxcfg_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int          IDX_W        = 8,
   parameter logic [15:0] IDX_PORT     = 16'h0022,
   parameter logic [15:0] DAT_PORT     = 16'h0023,
   parameter logic [7:0]  LOCK_IDX     = 8'h03,
   parameter logic [7:0]  UNLOCK_KEY   = 8'hC5,
   parameter logic [7:0]  SHADOW_IDX   = 8'h3F,
   parameter logic [7:0]  COMPAT_IDX   = 8'h20,
   parameter logic [7:0]  COMPAT_FLOOR = 8'hC0,
   parameter logic [7:0]  AUX_IDX      = 8'h29,
   parameter int          AUX_BIT      = 4,
   localparam int         NUM_REGS     = 1 << IDX_W,
   localparam int         FLAT_W       = NUM_REGS * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [BYTE_W-1:0] io_wdata,
   output logic [BYTE_W-1:0] io_rdata,
   input  logic              compat_mode,
   input  logic [BYTE_W-1:0] rtc_shadow,
   output logic [FLAT_W-1:0] cfg_flat,
   output logic              aux_port92_en
);
   initial begin : elab_checks
      if (IDX_W != 8)
         $fatal(1, "idxcfg_regfile: IDX_W must be 8, got %0d", IDX_W);
      if (AUX_BIT < 0 || AUX_BIT >= BYTE_W)
         $fatal(1, "idxcfg_regfile: AUX_BIT out of range");
      if (ADDR_W < 8)
         $fatal(1, "idxcfg_regfile: ADDR_W too narrow");
   end

   logic [IDX_W-1:0]  cur_index;
   logic [BYTE_W-1:0] lock_val;
   logic              idx_load;
   logic              dat_wr;
   logic              unlocked;
   logic              wr_accept;

   assign idx_load  = io_wr && (io_addr == ADDR_W'(IDX_PORT));
   assign dat_wr    = io_wr && (io_addr == ADDR_W'(DAT_PORT));
   assign lock_val  = cfg_flat[LOCK_IDX*BYTE_W +: BYTE_W];
   assign unlocked  = (lock_val == UNLOCK_KEY);
   assign wr_accept = dat_wr && (unlocked || (cur_index == IDX_W'(LOCK_IDX)));

   idxcfg_index_latch #(.IDX_W(IDX_W)) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (idx_load),
      .din   (io_wdata[IDX_W-1:0]),
      .idx_q (cur_index)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      logic sel_wr;
      assign sel_wr = wr_accept && (cur_index == IDX_W'(i));
      idxcfg_cell #(.IDX(8'(i))) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (sel_wr),
         .wdata (io_wdata),
         .q     (cfg_flat[i*BYTE_W +: BYTE_W])
      );
   end

   idxcfg_read_mux #(
      .ADDR_W       (ADDR_W),
      .IDX_W        (IDX_W),
      .IDX_PORT     (IDX_PORT),
      .DAT_PORT     (DAT_PORT),
      .SHADOW_IDX   (SHADOW_IDX),
      .COMPAT_IDX   (COMPAT_IDX),
      .COMPAT_FLOOR (COMPAT_FLOOR)
   ) u_rd (
      .io_addr     (io_addr),
      .cur_index   (cur_index),
      .cfg_flat    (cfg_flat),
      .compat_mode (compat_mode),
      .rtc_shadow  (rtc_shadow),
      .rdata       (io_rdata)
   );

   assign aux_port92_en = cfg_flat[AUX_IDX*BYTE_W + AUX_BIT];
endmodule

// File: rtl/idxcfg_regfile_chk.sv
module idxcfg_regfile_chk #(
   parameter int          ADDR_W     = 16,
   parameter int          FLAT_W     = 2048,
   parameter logic [15:0] IDX_PORT   = 16'h0022,
   parameter logic [15:0] DAT_PORT   = 16'h0023,
   parameter logic [7:0]  LOCK_IDX   = 8'h03,
   parameter logic [7:0]  UNLOCK_KEY = 8'hC5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr,
   input logic [ADDR_W-1:0] io_addr,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              compat_mode,
   input logic [7:0]        rtc_shadow,
   input logic [7:0]        cur_index,
   input logic [7:0]        lock_val,
   input logic [FLAT_W-1:0] cfg_flat
);
   logic is_dat;
   assign is_dat = (io_addr == ADDR_W'(DAT_PORT));

   p_index_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && io_addr == ADDR_W'(IDX_PORT) |=> cur_index == $past(io_wdata));

   p_lock_writable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && is_dat && cur_index == LOCK_IDX |=> lock_val == $past(io_wdata));

   p_locked_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && is_dat && cur_index != LOCK_IDX && lock_val != UNLOCK_KEY
      |=> $stable(cfg_flat));

   p_forced_21_r4: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && is_dat && cur_index == 8'h21 && lock_val == UNLOCK_KEY
      |=> cfg_flat[8'h21*8 + 2]);

   p_forced_2b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && is_dat && cur_index == 8'h2B && lock_val == UNLOCK_KEY
      |=> cfg_flat[8'h2B*8 + 6]);

   p_status_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cfg_flat[8'h35*8 +: 4]));

   p_compat_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      compat_mode && is_dat && (cur_index == 8'h20 || cur_index >= 8'hC0)
      |-> io_rdata == 8'hFF);

   p_shadow_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_dat && cur_index == 8'h3F |-> io_rdata == rtc_shadow);

   p_unmapped_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !is_dat |-> io_rdata == 8'hFF);
endmodule

bind idxcfg_regfile idxcfg_regfile_chk #(
   .ADDR_W     (ADDR_W),
   .FLAT_W     (FLAT_W),
   .IDX_PORT   (IDX_PORT),
   .DAT_PORT   (DAT_PORT),
   .LOCK_IDX   (LOCK_IDX),
   .UNLOCK_KEY (UNLOCK_KEY)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_wr       (io_wr),
   .io_addr     (io_addr),
   .io_wdata    (io_wdata),
   .io_rdata    (io_rdata),
   .compat_mode (compat_mode),
   .rtc_shadow  (rtc_shadow),
   .cur_index   (cur_index),
   .lock_val    (lock_val),
   .cfg_flat    (cfg_flat)
);

// File: tb/idxcfg_regfile_tb_top.sv
`timescale 1ns/1ps
module idxcfg_regfile_tb_top;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          io_wr = 1'b0;
   logic [15:0]   io_addr = 16'h0000;
   logic [7:0]    io_wdata = 8'h00;
   logic [7:0]    io_rdata;
   logic          compat_mode = 1'b0;
   logic [7:0]    rtc_shadow = 8'h00;
   logic [2047:0] cfg_flat;
   logic          aux_port92_en;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   idxcfg_regfile dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .io_wr         (io_wr),
      .io_addr       (io_addr),
      .io_wdata      (io_wdata),
      .io_rdata      (io_rdata),
      .compat_mode   (compat_mode),
      .rtc_shadow    (rtc_shadow),
      .cfg_flat      (cfg_flat),
      .aux_port92_en (aux_port92_en)
   );

   // {requirement number, index, write data, expected read}; unlocked file
   localparam logic [31:0] VEC [0:20] = '{
      32'h03_14FFBF,  // R3
      32'h03_15FFF1,  // R3
      32'h03_1CFF1F,  // R3
      32'h03_1EFF40,  // R3
      32'h03_22FFFD,  // R3
      32'h03_28FF3F,  // R3
      32'h03_36FFE5,  // R3
      32'h03_37FFEF,  // R3
      32'h03_3DFF07,  // R3
      32'h03_40FF3F,  // R3
      32'h04_210004,  // R4
      32'h04_21FFBF,  // R4
      32'h04_2B0040,  // R4
      32'h04_2BFFFF,  // R4
      32'h05_35FFF0,  // R5
      32'h05_350F00,  // R5
      32'h02_105A5A,  // R2
      32'h02_44A5A5,  // R2
      32'h0A_50FF00,  // R10
      32'h0A_02550F,  // R10
      32'h09_291010   // R9
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a;
      #1 d = io_rdata;
   endtask

   task automatic reg_write(input logic [7:0] idx, input logic [7:0] v);
      io_write(16'h0022, idx);
      io_write(16'h0023, v);
   endtask

   task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
      io_write(16'h0022, idx);
      io_read(16'h0023, d);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
      end
   end

   initial begin : main
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6 reset values
      reg_read(8'h02, rd); check("R6 reg02", rd, 8'h0F);
      reg_read(8'h10, rd); check("R6 reg10", rd, 8'hF1);
      reg_read(8'h11, rd); check("R6 reg11", rd, 8'hFF);
      reg_read(8'h15, rd); check("R6 reg15", rd, 8'h20);
      reg_read(8'h16, rd); check("R6 reg16", rd, 8'h30);
      reg_read(8'h19, rd); check("R6 reg19", rd, 8'h04);
      reg_read(8'h3C, rd); check("R6 reg3C", rd, 8'h03);
      reg_read(8'h3D, rd); check("R6 reg3D", rd, 8'h01);
      reg_read(8'h40, rd); check("R6 reg40", rd, 8'h03);
      reg_read(8'h03, rd); check("R6 reg03", rd, 8'h00);
      reg_read(8'h29, rd); check("R6 reg29", rd, 8'h00);
      check("R9 aux after reset", {7'd0, aux_port92_en}, 8'h00);

      // R2 writes refused while locked
      reg_write(8'h10, 8'h33);
      reg_read(8'h10, rd); check("R2 locked write", rd, 8'hF1);
      reg_write(8'h03, 8'hC5);
      reg_read(8'h03, rd); check("R2 lock write", rd, 8'hC5);
      reg_write(8'h10, 8'h33);
      reg_read(8'h10, rd); check("R2 unlocked write", rd, 8'h33);
      reg_write(8'h03, 8'h00);
      reg_write(8'h10, 8'h44);
      reg_read(8'h10, rd); check("R2 relocked write", rd, 8'h33);
      reg_write(8'h03, 8'hC5);

      // table walk
      for (int i = 0; i < 21; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d idx%02h", VEC[i][31:24], i, VEC[i][23:16]);
         reg_write(VEC[i][23:16], VEC[i][15:8]);
         reg_read(VEC[i][23:16], rd);
         check(tag, rd, VEC[i][7:0]);
      end

      // R9 aux output follows bit 4 of 29h
      check("R9 aux set", {7'd0, aux_port92_en}, 8'h01);
      reg_write(8'h29, 8'hEF);
      check("R9 aux clear", {7'd0, aux_port92_en}, 8'h00);

      // R1 index latch: data port follows the latest index
      io_write(16'h0022, 8'h16);
      io_read(16'h0023, rd); check("R1 index 16", rd, 8'h30);
      io_write(16'h0022, 8'h19);
      io_read(16'h0023, rd); check("R1 index 19", rd, 8'h04);

      // R10 index port and unmapped reads
      io_read(16'h0022, rd); check("R10 index port read", rd, 8'hFF);
      io_read(16'h0080, rd); check("R10 unmapped read", rd, 8'hFF);
      reg_write(8'hC3, 8'h77);
      reg_read(8'hC3, rd); check("R10 undefined index", rd, 8'h00);

      // R8 shadow index
      rtc_shadow = 8'h7E;
      reg_write(8'h3F, 8'h12);
      reg_read(8'h3F, rd); check("R8 shadow read", rd, 8'h7E);
      rtc_shadow = 8'h81;
      io_read(16'h0023, rd); check("R8 shadow follows", rd, 8'h81);

      // R7 compatibility reads
      reg_write(8'h20, 8'h12);
      reg_read(8'h20, rd); check("R7 idx20 compat off", rd, 8'h12);
      compat_mode = 1'b1;
      io_read(16'h0023, rd); check("R7 idx20 compat on", rd, 8'hFF);
      reg_read(8'hC0, rd); check("R7 idxC0 compat on", rd, 8'hFF);
      reg_read(8'hFF, rd); check("R7 idxFF compat on", rd, 8'hFF);
      reg_read(8'h10, rd); check("R7 idx10 compat on", rd, 8'h5A);
      compat_mode = 1'b0;
      reg_read(8'hC0, rd); check("R7 idxC0 compat off", rd, 8'h00);

      done = 1'b1;
      summary();
   end
endmodule